// File: doc/BRIEF.md
# Clocked Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM with a common-I/O data bus. It accepts one word per request through a ready/request handshake and turns each request into a complete memory bus cycle. It drives the address, an active-low chip select, an active-low write strobe and an active-low output enable. It also provides a separate outgoing data word with its own driver enable, and it samples the returned data word.

The clock period in nanoseconds and the memory's speed-grade timing figures are parameters. Every phase length in clock cycles is derived from them at elaboration time. Each length is the nanosecond value divided by the clock period, rounded up, and never less than one cycle. Writes are strobed by the write-enable line while output enable stays high for the whole cycle. After a read, the controller keeps its data driver off until the memory's outputs have had time to float.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, `ready` is 1; `mem_cs_n`, `mem_wr_n` and `mem_rd_n` are 1; `mem_drive` and `rd_valid` are 0.
- R2: `ready` is 1 only while no bus cycle is in progress, and then all memory strobes are inactive. A request presented while `ready` is 0 is ignored and starts no bus cycle.
- R3: A read (`req`=1, `wr`=0 at an edge with `ready`=1) applies the address with `mem_cs_n`=0 and `mem_rd_n`=0 on that edge. The data word is captured RD = max(ceil(T_AA/CLK_NS), ceil(T_OE/CLK_NS)) edges later, and `rd_data` holds the word stored at that address.
- R4: `rd_valid` is high for exactly one clock cycle per read, in the cycle after the capture edge.
- R5: After a read, `mem_rd_n` and `mem_cs_n` return to 1 at the capture edge. `ready` returns HZ = ceil(T_OHZ/CLK_NS) edges later, so the data driver cannot switch on within HZ cycles of output enable rising.
- R6: During a write, `mem_rd_n` stays 1 throughout. `mem_drive` switches on at the acceptance edge, one cycle before `mem_wr_n` falls.
- R7: `mem_wr_n` is low for exactly WP = max(ceil(T_WP/CLK_NS), ceil(T_DW/CLK_NS), ceil(T_WC/CLK_NS)-1) cycles, with WP never less than 1. Address and write data are stable during that time, and the word is written to the addressed location. `ready` returns on the edge where `mem_wr_n` rises.
- R8: `mem_drive` is never 1 while `mem_rd_n` is 0.
- R9: During a read, `mem_addr` stays stable for as long as `mem_rd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request, accepted when ready is 1 |
| ready | output | 1 | Controller idle, able to accept a request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Host word address |
| wdata | input | DW | Host write data |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-cycle strobe marking rd_data valid |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_wr_n | output | 1 | Memory write enable, active low |
| mem_rd_n | output | 1 | Memory output enable, active low |
| mem_wdata | output | DW | Data driven toward the memory |
| mem_drive | output | 1 | Enables the controller's data driver |
| mem_rdata | input | DW | Data returned by the memory |

## Verification
Counting from the acceptance edge, `rd_valid` is due in the cycle after edge RD and `ready` after edge RD+HZ. For a write, `mem_wr_n` falls after edge 1, rises and restores `ready` after edge 1+WP. The bench drives the request at a falling edge and then numbers every following falling edge from 1. At each numbered falling edge it compares the outputs with those edge counts, which it derives from the timing parameters with its own ceiling function. A behavioural memory model in the bench commits a write only when the write strobe rises. The bench reads each written location back to confirm the store.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int AW     = 14,
  parameter int DW     = 4,
  parameter int CLK_NS = 10,
  parameter int T_AA   = 10,
  parameter int T_OE   = 6,
  parameter int T_OHZ  = 6,
  parameter int T_WP   = 8,
  parameter int T_WC   = 10,
  parameter int T_DW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          ready,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_wr_n,
  output logic          mem_rd_n,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_drive,
  input  logic [DW-1:0] mem_rdata
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = max2(cyc(T_AA), cyc(T_OE));
  localparam int HZ_CYC = cyc(T_OHZ);
  localparam int WP_CYC = max2(max2(cyc(T_WP), cyc(T_DW)), cyc(T_WC) - 1);
  localparam int MAX_CYC = max2(max2(RD_CYC, HZ_CYC), WP_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_FLOAT, S_WSET, S_WPULSE} state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  assign ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_wr_n  <= 1'b1;
      mem_rd_n  <= 1'b1;
      mem_wdata <= '0;
      mem_drive <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          mem_cs_n <= 1'b0;
          cnt      <= '0;
          if (wr) begin
            mem_wdata <= wdata;
            mem_drive <= 1'b1;
            state     <= S_WSET;
          end else begin
            mem_rd_n <= 1'b0;
            state    <= S_READ;
          end
        end
        S_READ: if (cnt == CW'(RD_CYC - 1)) begin
          rd_data  <= mem_rdata;
          rd_valid <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_rd_n <= 1'b1;
          cnt      <= '0;
          state    <= S_FLOAT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_FLOAT: if (cnt == CW'(HZ_CYC - 1)) begin
          state <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_WSET: begin
          mem_wr_n <= 1'b0;
          cnt      <= '0;
          state    <= S_WPULSE;
        end
        S_WPULSE: if (cnt == CW'(WP_CYC - 1)) begin
          mem_wr_n  <= 1'b1;
          mem_cs_n  <= 1'b1;
          mem_drive <= 1'b0;
          state     <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int AW     = 14,
  parameter int DW     = 4,
  parameter int CLK_NS = 10,
  parameter int T_OHZ  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_wr_n,
  input logic          mem_rd_n,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_drive
);

  localparam int HZ_RAW = (T_OHZ + CLK_NS - 1) / CLK_NS;
  localparam int HZ_CYC = (HZ_RAW < 1) ? 1 : HZ_RAW;

  int oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_hi_cnt <= HZ_CYC;
    else if (!mem_rd_n) oe_hi_cnt <= 0;
    else if (oe_hi_cnt < HZ_CYC + 1) oe_hi_cnt <= oe_hi_cnt + 1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_wr_n && mem_rd_n && !mem_drive)); // R2
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_FLOAT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> (oe_hi_cnt >= HZ_CYC)); // R5
  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> mem_rd_n); // R6
  AST_DRIVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(mem_drive)); // R6
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !mem_drive); // R8
  AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && $past(!mem_rd_n)) |-> $stable(mem_addr)); // R9

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_OHZ(T_OHZ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n),
  .mem_rd_n(mem_rd_n), .mem_wdata(mem_wdata), .mem_drive(mem_drive)
);

// File: tb/sram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_bench;
  localparam int AW = 6, DW = 4, CLK_NS = 3;
  localparam int T_AA = 10, T_OE = 6, T_OHZ = 6, T_WP = 8, T_WC = 10, T_DW = 7;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = mx(cdiv(T_AA), cdiv(T_OE));
  localparam int E_HZ = cdiv(T_OHZ);
  localparam int E_WP = mx(mx(cdiv(T_WP), cdiv(T_DW)), cdiv(T_WC) - 1);

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rd_valid, mem_cs_n, mem_wr_n, mem_rd_n, mem_drive;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DW-1:0] mem [64];
  logic          wr_low_q = 0;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_d;

  always #10 clk = ~clk;

  sram_cycle_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_AA(T_AA), .T_OE(T_OE),
    .T_OHZ(T_OHZ), .T_WP(T_WP), .T_WC(T_WC), .T_DW(T_DW)) u_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_wdata(mem_wdata), .mem_drive(mem_drive), .mem_rdata(mem_rdata));

  assign mem_rdata = (!mem_cs_n && !mem_rd_n) ? mem[mem_addr] : '0;

  initial for (int i = 0; i < 64; i++) mem[i] = DW'((i * 5 + 3) & 15);

  always @(negedge clk) begin
    if (!mem_wr_n && !mem_cs_n) begin
      pend_a = mem_addr;
      pend_d = mem_wdata;
      wr_low_q = 1;
    end else if (mem_wr_n && wr_low_q) begin
      mem[pend_a] = pend_d;
      wr_low_q = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int v_first = 0, v_cnt = 0, r_first = 0, bad_drive = 0, bad_addr = 0, got = 0;
    @(negedge clk);
    chk("R2 ready before read", ready, 1);
    req = 1; wr = 0; addr = a;
    for (int n = 1; n <= E_RD + E_HZ + 3; n++) begin
      @(negedge clk);
      if (n == 1) req = 0;
      if (rd_valid) begin v_cnt++; if (v_first == 0) begin v_first = n; got = rd_data; end end
      if (ready && r_first == 0) r_first = n;
      if (mem_drive) bad_drive++;
      if (!mem_rd_n && mem_addr != a) bad_addr++;
    end
    chk("R3 rd_valid timing", v_first, E_RD + 1);
    chk("R3 read data", got, exp);
    chk("R4 rd_valid width", v_cnt, 1);
    chk("R5 ready after read", r_first, E_RD + E_HZ + 1);
    chk("R8 no drive in read", bad_drive, 0);
    chk("R9 read address", bad_addr, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int w_first = 0, w_cnt = 0, r_first = 0, oe_low = 0, drv1 = 0, bad = 0, cs_after = 0;
    @(negedge clk);
    chk("R2 ready before write", ready, 1);
    req = 1; wr = 1; addr = a; wdata = d;
    for (int n = 1; n <= E_WP + 5; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req = 0;
        drv1 = (mem_drive && mem_wr_n) ? 1 : 0;
        if (poke) begin req = 1; wr = 0; addr = a ^ 6'h15; end
      end
      if (poke && n == E_WP + 1) req = 0;
      if (!mem_wr_n) begin
        w_cnt++;
        if (w_first == 0) w_first = n;
        if (mem_addr != a || mem_wdata != d || !mem_drive) bad++;
      end
      if (!mem_rd_n) oe_low++;
      if (ready && r_first == 0) r_first = n;
      if (r_first != 0 && !mem_cs_n) cs_after++;
    end
    chk("R6 driver on before strobe", drv1, 1);
    chk("R6 output enable held high", oe_low, 0);
    chk("R7 strobe start", w_first, 2);
    chk("R7 strobe width", w_cnt, E_WP);
    chk("R7 address/data stable", bad, 0);
    chk("R7 ready after write", r_first, E_WP + 2);
    if (poke) chk("R2 busy request ignored", cs_after, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", ready, 1);
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 wr_n", mem_wr_n, 1);
    chk("R1 rd_n", mem_rd_n, 1);
    chk("R1 drive", mem_drive, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    do_read(6'd7, DW'((7 * 5 + 3) & 15));
    do_read(6'd63, DW'((63 * 5 + 3) & 15));
    do_write(6'd7, 4'hA, 0);
    do_read(6'd7, 4'hA);
    do_write(6'd0, 4'h5, 1);
    do_write(6'd63, 4'hF, 0);
    do_read(6'd0, 4'h5);
    do_read(6'd63, 4'hF);
    do_read(6'd0 ^ 6'h15, DW'((21 * 5 + 3) & 15));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule